// File: doc/BRIEF.md
# ULPI Link-Side PHY Register Access Engine

This block sits on the link side of an 8-bit ULPI bus and carries out PHY register reads and writes. A client raises a request with a direction flag, an 8-bit register address and, for writes, a data byte. The engine drives a command byte onto the shared data lines and steps through the remaining bytes using the PHY's NXT handshake. A write ends with a one-cycle STP strobe. A read hands the bus to the PHY and captures the byte that comes back.

Addresses that fit the short 6-bit field go out as an immediate command. When the `EXT_EN` parameter is set, addresses of 0x40 and above, and address 0x2F, go out as an extended command followed by a full address byte. If the PHY raises DIR while the link is still driving a register command, the link drops the bus, waits for DIR to fall and replays the whole operation from the command byte. It keeps doing this until the operation completes.

Top module: `ulpi_regacc`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `ulpi_stp` and `ulpi_data_oe` are all low.
- R2: The command byte carries bits [7:6] = 2'b10 for a write and 2'b11 for a read. Bits [5:0] hold the register address for an immediate command, or the code 6'h2F for an extended command.
- R3: An immediate write drives the command byte and then the data byte. The PHY's final stored register equals the requested address and data.
- R4: With `EXT_EN` = 1, an address whose bits [7:6] are nonzero or whose value is 0x2F is sent as an extended command. The full 8-bit address byte follows the command, ahead of any data byte.
- R5: Once the last write byte has been accepted with NXT, `ulpi_stp` is high for exactly one cycle with `ulpi_data_out` = 0x00. The engine then returns to idle.
- R6: After the last read byte is accepted, the link stops driving the bus. The first cycle seen with DIR high is the turnaround cycle. The byte on `ulpi_data_in` in the next cycle appears on `rdata` when `done` pulses.
- R7: If DIR is high while the link is driving a command, address or data byte, the link stops driving within one cycle and abandons that attempt without signalling `done`.
- R8: After an abort, the operation restarts from its command byte once DIR is low. It finishes with exactly one `done`.
- R9: A request is not accepted while DIR is high. `busy` stays low until DIR falls.
- R10: `ulpi_data_oe` is never high while `ulpi_dir` is high.
- R11: `busy` stays high from acceptance until completion. `done` is a single-cycle pulse, raised together with the return to idle, once per request.
- R12: While NXT is low, the byte on `ulpi_data_out` holds steady from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; held until `busy` rises |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read from the PHY |
| ulpi_dir | input | 1 | Bus direction from the PHY (1 = PHY drives) |
| ulpi_nxt | input | 1 | PHY accepts the current byte |
| ulpi_data_in | input | 8 | Data lines as driven by the PHY |
| ulpi_data_out | output | 8 | Data lines as driven by the link |
| ulpi_data_oe | output | 1 | Link output enable for the data lines |
| ulpi_stp | output | 1 | Stop strobe |

## Verification
The properties assume that the PHY raises NXT only while the link is driving a byte, and that the client holds `req_valid` steady until `busy` rises. They also assume that DIR, once raised for a read, stays high through the capture cycle. The bench's reactive PHY model keeps to these rules. It answers every byte with NXT, optionally after a few stall cycles. It raises DIR either as a proper read turnaround or as a deliberate three-cycle interruption on a chosen byte, and it holds DIR high in idle only before a request is issued.

// File: rtl/ulpi_regacc_pkg.sv
package ulpi_regacc_pkg;

    localparam int UW      = 8;          // ULPI data width
    localparam int IMM_W   = 6;          // immediate address field width
    localparam int OP_W    = UW - IMM_W; // opcode field width
    localparam logic [IMM_W-1:0] EXT_CODE = 6'h2F;
    localparam logic [OP_W-1:0]  OP_WR    = 2'b10;
    localparam logic [OP_W-1:0]  OP_RD    = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_STOP,
        ST_TURN,
        ST_CAPT,
        ST_HOLD
    } acc_state_e;

    typedef struct packed {
        acc_state_e     state;
        logic           wr;
        logic [UW-1:0]  addr;
        logic [UW-1:0]  wdata;
        logic [UW-1:0]  rdata;
        logic           done;
    } acc_regs_t;

endpackage

// File: rtl/ulpi_cmd_build.sv
module ulpi_cmd_build
    import ulpi_regacc_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic          wr,
    input  logic [UW-1:0] addr,
    output logic [UW-1:0] cmd,
    output logic          ext
);

    generate
        if (EXT_EN) begin : g_ext
            // long form for anything outside the short field or colliding with the escape code
            assign ext = (addr[UW-1:IMM_W] != '0) || (addr[IMM_W-1:0] == EXT_CODE);
        end else begin : g_imm
            assign ext = 1'b0;
        end
    endgenerate

    always_comb begin
        cmd[UW-1:IMM_W] = wr ? OP_WR : OP_RD;
        cmd[IMM_W-1:0]  = ext ? EXT_CODE : addr[IMM_W-1:0];
    end

endmodule

// File: rtl/ulpi_tx_mux.sv
module ulpi_tx_mux
    import ulpi_regacc_pkg::*;
(
    input  acc_state_e    state,
    input  logic [UW-1:0] cmd,
    input  logic [UW-1:0] addr,
    input  logic [UW-1:0] wdata,
    input  logic          dir,
    output logic [UW-1:0] data_out,
    output logic          oe,
    output logic          stp
);

    logic drive;

    always_comb begin
        data_out = '0;
        drive    = 1'b0;
        stp      = 1'b0;
        unique case (state)
            ST_CMD:   begin data_out = cmd;   drive = 1'b1; end
            ST_ADDR:  begin data_out = addr;  drive = 1'b1; end
            ST_WDATA: begin data_out = wdata; drive = 1'b1; end
            ST_STOP:  begin drive = 1'b1; stp = 1'b1; end
            default:  ;
        endcase
        oe = drive & ~dir;
    end

endmodule

// File: rtl/ulpi_regacc.sv
module ulpi_regacc
    import ulpi_regacc_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [7:0]    req_addr,
    input  logic [7:0]    req_wdata,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rdata,
    input  logic          ulpi_dir,
    input  logic          ulpi_nxt,
    input  logic [7:0]    ulpi_data_in,
    output logic [7:0]    ulpi_data_out,
    output logic          ulpi_data_oe,
    output logic          ulpi_stp
);

    acc_regs_t     q, d;
    logic [UW-1:0] cmd_byte;
    logic          is_ext;

    ulpi_cmd_build #(.EXT_EN(EXT_EN)) u_cmd (
        .wr   (q.wr),
        .addr (q.addr),
        .cmd  (cmd_byte),
        .ext  (is_ext)
    );

    ulpi_tx_mux u_mux (
        .state    (q.state),
        .cmd      (cmd_byte),
        .addr     (q.addr),
        .wdata    (q.wdata),
        .dir      (ulpi_dir),
        .data_out (ulpi_data_out),
        .oe       (ulpi_data_oe),
        .stp      (ulpi_stp)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid && !ulpi_dir) begin
                    d.wr    = req_write;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                if (ulpi_dir)          d.state = ST_HOLD;
                else if (ulpi_nxt)     d.state = is_ext ? ST_ADDR
                                               : (q.wr ? ST_WDATA : ST_TURN);
            end
            ST_ADDR: begin
                if (ulpi_dir)          d.state = ST_HOLD;
                else if (ulpi_nxt)     d.state = q.wr ? ST_WDATA : ST_TURN;
            end
            ST_WDATA: begin
                if (ulpi_dir)          d.state = ST_HOLD;
                else if (ulpi_nxt)     d.state = ST_STOP;
            end
            ST_STOP: begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
            end
            ST_TURN: begin
                // the first cycle with the PHY owning the bus is the turnaround
                if (ulpi_dir)          d.state = ST_CAPT;
            end
            ST_CAPT: begin
                if (ulpi_dir) begin
                    d.rdata = ulpi_data_in;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!ulpi_dir)         d.state = ST_CMD;
            end
            default:                   d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, wr: 1'b0, addr: '0, wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy  = (q.state != ST_IDLE);
    assign done  = q.done;
    assign rdata = q.rdata;

endmodule

// File: rtl/ulpi_regacc_chk.sv
module ulpi_regacc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir,
    input logic       nxt,
    input logic       oe,
    input logic [7:0] dout,
    input logic       stp,
    input logic       busy,
    input logic       done
);

    // R10
    bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> !oe);

    // R5
    stp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp |=> !stp);

    // R5
    stp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp |-> (dout == 8'h00));

    // R12
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !nxt && !stp) |=> $stable(dout));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    dir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dir) |=> !busy);

endmodule

bind ulpi_regacc ulpi_regacc_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .dir  (ulpi_dir),
    .nxt  (ulpi_nxt),
    .oe   (ulpi_data_oe),
    .dout (ulpi_data_out),
    .stp  (ulpi_stp),
    .busy (busy),
    .done (done)
);

// File: tb/sim_ulpi_regacc.sv
module sim_ulpi_regacc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic       busy, done, oe, stp;
    logic [7:0] rdata, dout;
    logic       dir = 1'b0, nxt = 1'b0;
    logic [7:0] din = '0;

    always #4 clk = ~clk;   // 125 MHz

    ulpi_regacc #(.EXT_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_data_in(din),
        .ulpi_data_out(dout), .ulpi_data_oe(oe), .ulpi_stp(stp)
    );

    typedef struct {
        bit         wr;
        logic [7:0] addr;
        logic [7:0] cmd;
        logic [7:0] data;
        int         cmds;
    } exp_t;

    exp_t       sb[$];
    int         n_cmp = 0, n_bad = 0;
    logic [7:0] phy_regs [256];
    logic [7:0] shadow   [256];

    // stimulus controls (written by driver only)
    int stall_n = 0, abort_at = 0, cmd_base = 0;
    bit hold_dir = 1'b0;
    // PHY model observations (written by PHY only)
    int         cmd_total = 0;
    logic [7:0] seen_cmd = '0, seen_full = '0, seen_wd = '0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // reactive PHY model, acts on falling edges
    initial begin
        int  ph = 0, st_left = 0, ab = 0;
        bit  in_cmd = 0, pw = 0, pext = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ph = 0; in_cmd = 0; nxt = 0; dir = 0; din = '0;
                continue;
            end
            case (ph)
                0: begin
                    nxt = 0; dir = hold_dir; din = '0;
                    if (oe && dout[7]) begin
                        if (!in_cmd) begin
                            in_cmd = 1; seen_cmd = dout; cmd_total++;
                            st_left = stall_n;
                        end else begin
                            chk(dout == seen_cmd, "R12", dout, seen_cmd);
                        end
                        if (abort_at == 1 && (cmd_total - cmd_base) == 1) begin
                            in_cmd = 0; dir = 1; din = 8'h5A; ab = 3; ph = 5;
                        end else if (st_left > 0) begin
                            st_left--;
                        end else begin
                            in_cmd = 0; nxt = 1;
                            pw   = (dout[7:6] == 2'b10);
                            pext = (dout[5:0] == 6'h2F);
                            seen_full = {2'b00, dout[5:0]};
                            ph = pext ? 1 : (pw ? 2 : 3);
                        end
                    end
                end
                1: begin
                    if (abort_at == 2 && (cmd_total - cmd_base) == 1) begin
                        nxt = 0; dir = 1; din = 8'h5A; ab = 3; ph = 5;
                    end else begin
                        seen_full = dout; nxt = 1; ph = pw ? 2 : 3;
                    end
                end
                2: begin
                    if (abort_at == 2 && (cmd_total - cmd_base) == 1) begin
                        nxt = 0; dir = 1; din = 8'h5A; ab = 3; ph = 5;
                    end else begin
                        seen_wd = dout; nxt = 1; ph = 4;
                    end
                end
                4: begin
                    nxt = 0;
                    chk(stp == 1'b1, "R5", stp, 1);
                    chk(dout == 8'h00, "R5", dout, 0);
                    phy_regs[seen_full] = seen_wd;
                    ph = 0;
                end
                3: begin
                    nxt = 0; dir = 1; din = 8'h00;
                    chk(oe == 1'b0, "R6", oe, 0);
                    ph = 6;
                end
                6: begin din = phy_regs[seen_full]; ph = 7; end
                7: begin dir = 0; din = '0; ph = 0; end
                5: begin
                    chk(oe == 1'b0, "R7", oe, 0);
                    chk(done == 1'b0, "R7", done, 0);
                    if (ab > 1) ab--;
                    else begin dir = 0; din = '0; ph = 0; end
                end
                default: ph = 0;
            endcase
        end
    end

    // monitor: compares each completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R11", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(seen_cmd == e.cmd, "R2", seen_cmd, e.cmd);
                    chk(seen_full == e.addr, e.cmd[5:0] == 6'h2F ? "R4" : "R3",
                        seen_full, e.addr);
                    if (e.wr) chk(phy_regs[e.addr] == e.data, "R3", phy_regs[e.addr], e.data);
                    else      chk(rdata == e.data, "R6", rdata, e.data);
                    chk((cmd_total - cmd_base) == e.cmds, "R8", cmd_total - cmd_base, e.cmds);
                end
            end
        end
    end

    task automatic do_op(input bit wr, input logic [7:0] a, input logic [7:0] dv,
                         input int stall, input int abrt, input int hold);
        exp_t e;
        bit   ext;
        ext    = (a[7:6] != 2'b00) || (a[5:0] == 6'h2F);
        e.wr   = wr;
        e.addr = a;
        e.cmd  = {wr ? 2'b10 : 2'b11, ext ? 6'h2F : a[5:0]};
        e.data = wr ? dv : shadow[a];
        e.cmds = (abrt != 0) ? 2 : 1;
        if (wr) shadow[a] = dv;
        stall_n  = stall;
        abort_at = abrt;
        cmd_base = cmd_total;
        sb.push_back(e);
        if (hold > 0) begin hold_dir = 1; @(negedge clk); end
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = dv;
        if (hold > 0) begin
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(busy == 1'b0, "R9", busy, 0);
                chk(oe == 1'b0, "R10", oe, 0);
            end
            hold_dir = 0;
        end
        do @(negedge clk); while (!busy);
        req_valid = 0;
        do begin
            @(negedge clk);
            if (busy) chk(done == 1'b0, "R11", done, 0);
        end while (busy);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            phy_regs[i] = 8'(i) ^ 8'hA5;
            shadow[i]   = 8'(i) ^ 8'hA5;
        end
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1", {busy, done}, 0);
        chk(oe == 0 && stp == 0, "R1", {oe, stp}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && oe == 0 && stp == 0, "R1",
            {busy, done, oe, stp}, 0);

        do_op(1, 8'h05, 8'h3C, 0, 0, 0);   // R3 immediate write
        do_op(0, 8'h05, 8'h00, 0, 0, 0);   // R6 immediate read back
        do_op(0, 8'h10, 8'h00, 0, 0, 0);   // R6 reset value
        do_op(1, 8'h2F, 8'h77, 0, 0, 0);   // R4 escape-code address
        do_op(0, 8'h2F, 8'h00, 0, 0, 0);   // R4 extended read
        do_op(1, 8'h9A, 8'hE1, 2, 0, 0);   // R12 stalled extended write
        do_op(0, 8'hC3, 8'h00, 3, 0, 0);   // R12 stalled extended read
        do_op(1, 8'h3F, 8'h42, 0, 1, 0);   // R7 R8 abort on command
        do_op(1, 8'h81, 8'h18, 0, 2, 0);   // R7 R8 abort on address byte
        do_op(0, 8'h3F, 8'h00, 0, 1, 0);   // R8 read after abort
        do_op(1, 8'h07, 8'hD0, 0, 2, 0);   // R7 abort on data byte
        do_op(1, 8'h00, 8'h99, 1, 0, 4);   // R9 request held off by DIR
        do_op(0, 8'h81, 8'h00, 0, 2, 0);   // R8 extended read after abort
        do_op(0, 8'h07, 8'h00, 0, 0, 0);   // R3 check aborted write landed once

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R11", sb.size(), 0);
        finish_run();
    end

endmodule